// File: doc/BRIEF.md
# Asynchronous SRAM Module Controller

This block sits between a synchronous host port and a 32-bit asynchronous static RAM module made of four 8-bit byte lanes. The lanes share a 17-bit address bus and one active-low output enable. Each lane has its own active-low chip select and active-low write enable. The host presents one request at a time with a valid/ready handshake. The controller turns the request into a read or write cycle on the memory pins. It sizes every pulse in whole clock cycles, taken from three parameters: read access length, write pulse length and bus turnaround gap.

The host can pick the data width of each request at run time: a 32-bit word, a 16-bit halfword or an 8-bit byte. In the narrow widths the low host address bits choose which lanes take part. The write data is repeated across the lanes. Read data comes back right-aligned in the response word.

The data pins are modelled as separate inbound and outbound buses plus a drive-enable signal. The pad ring builds the tri-state buffer from these.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after a synchronous reset, every chip select, write enable and the output enable are high, the data drive-enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read in 32-bit organisation (`org_mode` = 0) pulls all four chip selects and the output enable low, with every write enable high. It returns the full word on `rsp_rdata` together with a `rsp_valid` pulse lasting exactly one cycle.
- R3: A write in 32-bit organisation drives `mem_addr` = `req_addr[16:0]`. It selects and write-enables exactly the lanes whose `req_be` bit is set, where bit i belongs to data bits 8i+7..8i. Unselected lanes keep their old contents.
- R4: In 16-bit organisation (`org_mode` = 1), `mem_addr` = `req_addr[17:1]`, and `req_addr[0]` picks lanes 0-1 (value 0) or lanes 2-3 (value 1). A write stores `req_wdata[15:0]` into both halves of the data bus and uses `req_be[1:0]` as the mask within the chosen pair. A read returns the chosen pair in `rsp_rdata[15:0]`, with the upper bits zero.
- R5: In 8-bit organisation (`org_mode` = 2), `mem_addr` = `req_addr[18:2]`, and `req_addr[1:0]` names the only lane whose chip select, and for a write whose write enable, goes low. The byte mask is ignored. A write stores `req_wdata[7:0]`. A read returns the byte in `rsp_rdata[7:0]`, with the upper bits zero.
- R6: A read holds its chip selects and the output enable low for exactly T_RD cycles. The data is captured at the clock edge that ends the access.
- R7: A write holds its write enables low for exactly T_WP cycles. The data drive-enable is high in exactly those cycles. No write enable is low without its chip select, and the address stays stable while any chip select stays low.
- R8: After a read, the data drive-enable does not rise until at least T_TURN cycles after the output enable has returned high. It is never high while the output enable is low.
- R9: `req_ready` is low from the acceptance of a request until its cycle ends, and a `req_valid` raised while `req_ready` is low has no effect.
- R10: The unused organisation code (`org_mode` = 3) behaves as 32-bit organisation. The organisation is sampled when a request is accepted.
- R11: With the default parameters and a 100 MHz clock, the generated cycles meet these limits: read access at least 15 ns, write pulse at least 13 ns, write data valid at least 10 ns before the write ends, and a turnaround gap of at least 8 ns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| org_mode | input | 2 | Organisation: 0 word, 1 halfword, 2 byte, 3 treated as word |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller ready to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW+2 | Host address in units of the chosen organisation |
| req_wdata | input | 32 | Write data, right-aligned for narrow organisations |
| req_be | input | 4 | Byte mask for 32-bit and 16-bit writes |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 32 | Read data, right-aligned |
| mem_addr | output | AW | Shared memory address |
| mem_cs_n | output | 4 | Per-lane active-low chip select |
| mem_we_n | output | 4 | Per-lane active-low write enable |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq_out | output | 32 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 32 | Data returned by the memory |

## Verification
The assertions check rules that hold on every cycle:
- a write enable is never low without its chip select;
- the controller never drives data while the memory's outputs are enabled;
- the data drive is tied to the write strobe;
- the address holds during a select;
- ready stays low while a cycle is in progress;
- the response pulse lasts one cycle;
- write-pulse length, read-access length and the turnaround gap match their parameters, measured with counters.

Only the bench scenarios can show that lane selection and address slicing are right for each organisation, and that masked and byte writes leave their neighbours intact in the memory. They also show that a stray request during a busy cycle leaves the memory untouched, and that the nanosecond limits are met at the chosen clock.

// File: rtl/asram_pkg.sv
package asram_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    ORG_X32  = 2'd0,
    ORG_X16  = 2'd1,
    ORG_X8   = 2'd2,
    ORG_RSVD = 2'd3
  } org_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TURN  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } seq_st_e;
endpackage

// File: rtl/asram_lane_map.sv
module asram_lane_map
  import asram_pkg::*;
#(
  parameter int AW     = 17,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W,
  localparam int HW    = AW + 2
) (
  input  org_e              org,
  input  logic [HW-1:0]     haddr,
  input  logic [LANES-1:0]  be,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  output logic [AW-1:0]     maddr,
  output logic [LANES-1:0]  lane_en,
  output logic [DW-1:0]     lane_data
);
  logic [1:0] pair_en;

  // Address slicing and lane choice per organisation.
  always_comb begin
    pair_en = wr ? be[1:0] : 2'b11;
    case (org)
      ORG_X16: begin
        maddr   = haddr[AW:1];
        lane_en = haddr[0] ? {pair_en, 2'b00} : {2'b00, pair_en};
      end
      ORG_X8: begin
        maddr   = haddr[AW+1:2];
        lane_en = 4'b0001 << haddr[1:0];
      end
      default: begin
        maddr   = haddr[AW-1:0];
        lane_en = wr ? be : '1;
      end
    endcase
  end

  // Replicate narrow write data onto every lane that could be chosen.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_data[i*LANE_W +: LANE_W] =
      (org == ORG_X8)  ? wdata[LANE_W-1:0] :
      (org == ORG_X16) ? wdata[(i%2)*LANE_W +: LANE_W] :
                         wdata[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/asram_rd_align.sv
module asram_rd_align
  import asram_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  org_e          org,
  input  logic [1:0]    sub,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] aligned
);
  always_comb begin
    aligned = '0;
    case (org)
      ORG_X16: aligned[2*LANE_W-1:0] = raw[sub[0]*2*LANE_W +: 2*LANE_W];
      ORG_X8:  aligned[LANE_W-1:0]   = raw[sub*LANE_W +: LANE_W];
      default: aligned = raw;
    endcase
  end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int AW     = 17,
  parameter int DW     = 32,
  parameter int T_RD   = 2,
  parameter int T_WP   = 2,
  parameter int T_TURN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  output logic             req_ready,
  input  org_e             org_in,
  input  logic [1:0]       sub_in,
  input  logic [AW-1:0]    map_addr,
  input  logic [LANES-1:0] map_lanes,
  input  logic [DW-1:0]    map_data,
  input  logic [DW-1:0]    rd_aligned,
  output org_e             org_q,
  output logic [1:0]       sub_q,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic [LANES-1:0] mem_cs_n,
  output logic [LANES-1:0] mem_we_n,
  output logic             mem_oe_n,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe
);
  localparam int CMAX = (T_RD > T_WP) ? T_RD : T_WP;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int TW   = $clog2(T_TURN + 1);

  seq_st_e          state;
  logic [CW-1:0]    cnt;
  logic [TW-1:0]    turn_cnt;
  logic [LANES-1:0] lanes_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      turn_cnt   <= '0;
      lanes_q    <= '0;
      org_q      <= ORG_X32;
      sub_q      <= '0;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      mem_addr   <= '0;
      mem_cs_n   <= '1;
      mem_we_n   <= '1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (turn_cnt != '0) turn_cnt <= turn_cnt - 1'b1;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            req_ready  <= 1'b0;
            mem_addr   <= map_addr;
            lanes_q    <= map_lanes;
            mem_dq_out <= map_data;
            org_q      <= org_in;
            sub_q      <= sub_in;
            if (!req_write) begin
              mem_cs_n <= ~map_lanes;
              mem_oe_n <= 1'b0;
              cnt      <= CW'(T_RD - 1);
              state    <= ST_READ;
            end else if (turn_cnt <= TW'(1)) begin
              mem_cs_n  <= ~map_lanes;
              mem_we_n  <= ~map_lanes;
              mem_dq_oe <= 1'b1;
              cnt       <= CW'(T_WP - 1);
              state     <= ST_WRITE;
            end else begin
              state <= ST_TURN;
            end
          end
        end
        ST_TURN: begin
          if (turn_cnt <= TW'(1)) begin
            mem_cs_n  <= ~lanes_q;
            mem_we_n  <= ~lanes_q;
            mem_dq_oe <= 1'b1;
            cnt       <= CW'(T_WP - 1);
            state     <= ST_WRITE;
          end
        end
        ST_READ: begin
          if (cnt == '0) begin
            mem_cs_n  <= '1;
            mem_oe_n  <= 1'b1;
            rsp_rdata <= rd_aligned;
            rsp_valid <= 1'b1;
            req_ready <= 1'b1;
            turn_cnt  <= TW'(T_TURN);
            state     <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WRITE: begin
          if (cnt == '0) begin
            mem_cs_n  <= '1;
            mem_we_n  <= '1;
            mem_dq_oe <= 1'b0;
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW     = 17,
  parameter int LANE_W = 8,
  parameter int T_RD   = 2,
  parameter int T_WP   = 2,
  parameter int T_TURN = 2,
  localparam int DW    = LANES * LANE_W,
  localparam int HW    = AW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       org_mode,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [HW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic [LANES-1:0] mem_cs_n,
  output logic [LANES-1:0] mem_we_n,
  output logic             mem_oe_n,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_in
);
  org_e             org_in;
  org_e             org_q;
  logic [1:0]       sub_q;
  logic [AW-1:0]    map_addr;
  logic [LANES-1:0] map_lanes;
  logic [DW-1:0]    map_data;
  logic [DW-1:0]    rd_aligned;

  assign org_in = org_e'(org_mode);

  asram_lane_map #(.AW(AW), .LANE_W(LANE_W)) u_map (
    .org       (org_in),
    .haddr     (req_addr),
    .be        (req_be),
    .wr        (req_write),
    .wdata     (req_wdata),
    .maddr     (map_addr),
    .lane_en   (map_lanes),
    .lane_data (map_data)
  );

  asram_rd_align #(.LANE_W(LANE_W)) u_align (
    .org     (org_q),
    .sub     (sub_q),
    .raw     (mem_dq_in),
    .aligned (rd_aligned)
  );

  asram_seq #(
    .AW(AW), .DW(DW), .T_RD(T_RD), .T_WP(T_WP), .T_TURN(T_TURN)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .org_in     (org_in),
    .sub_in     (req_addr[1:0]),
    .map_addr   (map_addr),
    .map_lanes  (map_lanes),
    .map_data   (map_data),
    .rd_aligned (rd_aligned),
    .org_q      (org_q),
    .sub_q      (sub_q),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW     = 17,
  parameter int T_RD   = 2,
  parameter int T_WP   = 2,
  parameter int T_TURN = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_cs_n,
  input logic [3:0]    mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe
);
  logic [7:0] we_run;
  logic [7:0] oe_run;
  logic [7:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_run <= '0;
      oe_run <= '0;
      gap    <= 8'hFF;
    end else begin
      we_run <= (&mem_we_n) ? 8'd0 : we_run + 8'd1;
      oe_run <= mem_oe_n ? 8'd0 : oe_run + 8'd1;
      if (!mem_oe_n)        gap <= 8'd0;
      else if (gap != 8'hFF) gap <= gap + 8'd1;
    end
  end

  p_we_inside_cs_r7: assert property (@(posedge clk) disable iff (rst)
    ((~mem_we_n) & mem_cs_n) == 4'b0000);

  p_no_drive_when_oe_r8: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  p_drive_with_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe == !(&mem_we_n));

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
    !(&mem_cs_n) |-> !req_ready);

  p_rsp_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!(&mem_cs_n) && !(&$past(mem_cs_n))) |-> $stable(mem_addr));

  p_we_width_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(&mem_we_n) |-> (we_run == 8'(T_WP)));

  p_rd_width_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_run == 8'(T_RD)));

  p_turn_gap_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (gap >= 8'(T_TURN)));
endmodule

bind asram_ctrl asram_ctrl_chk #(
  .AW(AW), .T_RD(T_RD), .T_WP(T_WP), .T_TURN(T_TURN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
  localparam int AW = 17, HW = AW + 2, T_RD = 2, T_WP = 2, T_TURN = 2, CLK_NS = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    org_mode = 2'd0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [HW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [3:0]    req_be = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_cs_n;
  logic [3:0]    mem_we_n;
  logic          mem_oe_n;
  logic [31:0]   mem_dq_out;
  logic          mem_dq_oe;
  logic [31:0]   mem_dq_in = '0;

  always #5 clk = ~clk;

  asram_ctrl #(.AW(AW), .T_RD(T_RD), .T_WP(T_WP), .T_TURN(T_TURN)) u_dut (
    .clk(clk), .rst(rst), .org_mode(org_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Behavioural memory, keyed by word address * 4 + lane.
  logic [7:0] phys [int];
  logic [7:0] shadow [int];

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      int k;
      k = int'(mem_addr) * 4 + i;
      if (!mem_cs_n[i] && !mem_we_n[i]) begin
        if (!mem_dq_oe) check(1'b0, "R7", "write strobe without data drive", 0, 1);
        phys[k] = mem_dq_out[i*8 +: 8];
      end
      if (!mem_cs_n[i] && !mem_oe_n && mem_we_n[i])
        mem_dq_in[i*8 +: 8] <= phys.exists(k) ? phys[k] : 8'hA5;
      else
        mem_dq_in[i*8 +: 8] <= 8'h00;
    end
  end

  // Pin timing monitor (R6, R7, R8, R11).
  int  oe_run = 0, we_run = 0, drv_run = 0, gap = 1000;
  logic prev_oe = 1'b1, prev_we = 1'b1, prev_drv = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!prev_oe && mem_oe_n) begin
        check(oe_run == T_RD, "R6", "read access cycles", oe_run, T_RD);
        check(oe_run * CLK_NS >= 15, "R11", "read access ns", oe_run * CLK_NS, 15);
      end
      if (!prev_we && (&mem_we_n)) begin
        check(we_run == T_WP, "R7", "write pulse cycles", we_run, T_WP);
        check(we_run * CLK_NS >= 13, "R11", "write pulse ns", we_run * CLK_NS, 13);
        check(drv_run * CLK_NS >= 10, "R11", "data setup ns", drv_run * CLK_NS, 10);
      end
      if (!prev_drv && mem_dq_oe && gap < 1000) begin
        check(gap >= T_TURN, "R8", "turnaround cycles", gap, T_TURN);
        check(gap * CLK_NS >= 8, "R11", "turnaround ns", gap * CLK_NS, 8);
      end
      if (mem_dq_oe && !mem_oe_n) check(1'b0, "R8", "bus conflict", 1, 0);
    end
    oe_run  = mem_oe_n ? 0 : oe_run + 1;
    we_run  = (&mem_we_n) ? 0 : we_run + 1;
    drv_run = mem_dq_oe ? drv_run + 1 : 0;
    if (!mem_oe_n) gap = 0; else if (gap < 1000) gap = gap + 1;
    prev_oe  = mem_oe_n;
    prev_we  = &mem_we_n;
    prev_drv = mem_dq_oe;
  end

  // Scoreboard.
  logic [31:0] exp_q [$];
  string       tag_q [$];
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected response", rsp_rdata, 0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata === e, t, "read data", rsp_rdata, e);
      end
    end
  end

  function automatic logic [7:0] sh(input int k);
    return shadow.exists(k) ? shadow[k] : 8'hA5;
  endfunction

  function automatic logic [3:0] exp_lanes(input logic [1:0] org, input bit wr,
                                           input logic [HW-1:0] a, input logic [3:0] be);
    logic [1:0] p;
    p = wr ? be[1:0] : 2'b11;
    case (org)
      2'd1:    return a[0] ? {p, 2'b00} : {2'b00, p};
      2'd2:    return 4'b0001 << a[1:0];
      default: return wr ? be : 4'hF;
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_maddr(input logic [1:0] org, input logic [HW-1:0] a);
    case (org)
      2'd1:    return a[AW:1];
      2'd2:    return a[AW+1:2];
      default: return a[AW-1:0];
    endcase
  endfunction

  task automatic shadow_write(input logic [1:0] org, input logic [HW-1:0] a,
                              input logic [31:0] d, input logic [3:0] be);
    int base;
    base = int'(exp_maddr(org, a)) * 4;
    case (org)
      2'd1: for (int j = 0; j < 2; j++)
              if (be[j]) shadow[base + (a[0] ? 2 : 0) + j] = d[j*8 +: 8];
      2'd2: shadow[base + int'(a[1:0])] = d[7:0];
      default: for (int j = 0; j < 4; j++)
                 if (be[j]) shadow[base + j] = d[j*8 +: 8];
    endcase
  endtask

  function automatic logic [31:0] shadow_read(input logic [1:0] org, input logic [HW-1:0] a);
    int base;
    base = int'(exp_maddr(org, a)) * 4;
    case (org)
      2'd1: begin
        int o;
        o = base + (a[0] ? 2 : 0);
        return {16'h0, sh(o + 1), sh(o)};
      end
      2'd2:    return {24'h0, sh(base + int'(a[1:0]))};
      default: return {sh(base + 3), sh(base + 2), sh(base + 1), sh(base)};
    endcase
  endfunction

  task automatic issue(input bit wr, input logic [1:0] org, input logic [HW-1:0] a,
                       input logic [31:0] d, input logic [3:0] be, input string req);
    logic [3:0] el;
    el = exp_lanes(org, wr, a, be);
    if (wr) shadow_write(org, a, d, be);
    else begin
      exp_q.push_back(shadow_read(org, a));
      tag_q.push_back(req);
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; org_mode = org;
    req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    for (int n = 0; n < 20 && (&mem_cs_n); n++) @(negedge clk);
    check(mem_cs_n == ~el, req, "chip selects", mem_cs_n, ~el);
    check(mem_addr == exp_maddr(org, a), req, "memory address", mem_addr, exp_maddr(org, a));
    if (wr) check(mem_we_n == ~el, req, "write enables", mem_we_n, ~el);
    else    check(!mem_oe_n && (&mem_we_n), req, "read strobes", {mem_oe_n, mem_we_n}, 5'h0F);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(&mem_cs_n && &mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid,
          "R1", "reset state", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid},
          {4'hF, 4'hF, 1'b1, 1'b0, 1'b1, 1'b0});
    rst = 1'b0;
    @(negedge clk);
    check(&mem_cs_n && mem_oe_n && req_ready, "R1", "idle after reset",
          {mem_cs_n, mem_oe_n, req_ready}, {4'hF, 2'b11});

    // Word organisation.
    issue(1, 2'd0, 19'd5, 32'h11223344, 4'hF, "R3");
    issue(0, 2'd0, 19'd5, 32'h0, 4'h0, "R2");
    issue(1, 2'd0, 19'd5, 32'hAABBCCDD, 4'b0101, "R3");  // write right after read: R8
    issue(0, 2'd0, 19'd5, 32'h0, 4'h0, "R3");
    issue(1, 2'd0, 19'h1FFFF, 32'hCAFEF00D, 4'hF, "R3");
    issue(0, 2'd0, 19'h1FFFF, 32'h0, 4'h0, "R2");

    // Halfword organisation.
    issue(1, 2'd1, 19'd3, 32'h0000BEEF, 4'b0011, "R4");
    issue(1, 2'd1, 19'd2, 32'h00001234, 4'b0010, "R4");
    issue(0, 2'd1, 19'd3, 32'h0, 4'h0, "R4");
    issue(0, 2'd1, 19'd2, 32'h0, 4'h0, "R4");
    issue(0, 2'd0, 19'd1, 32'h0, 4'h0, "R4");

    // Byte organisation, mask ignored.
    for (int b = 0; b < 4; b++)
      issue(1, 2'd2, 19'(8 + b), 32'hFFFFFF10 + 32'(b), 4'h0, "R5");
    issue(0, 2'd0, 19'd2, 32'h0, 4'h0, "R5");
    issue(0, 2'd2, 19'd10, 32'h0, 4'h0, "R5");
    issue(1, 2'd2, 19'h7FFFF, 32'h0000005A, 4'h0, "R5");
    issue(0, 2'd2, 19'h7FFFF, 32'h0, 4'h0, "R5");

    // Reserved organisation code behaves as word.
    issue(0, 2'd3, 19'd5, 32'h0, 4'h0, "R10");

    // Stray request while busy is ignored.
    exp_q.push_back(shadow_read(2'd0, 19'd5));
    tag_q.push_back("R9");
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; org_mode = 2'd0; req_addr = 19'd5;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check(!req_ready, "R9", "ready low while busy", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b1; req_wdata = 32'hDEADDEAD; req_be = 4'hF;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    issue(0, 2'd0, 19'd5, 32'h0, 4'h0, "R9");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R2", "responses outstanding", exp_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule